// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Write Receiver

This block is the target side of a two-wire serial bus for a small byte-wide EEPROM. It handles only write traffic. The SCL and SDA lines are brought into a fast system clock through synchronisers. The block detects bus Start and Stop conditions, then collects three kinds of byte in turn: a control byte, a word address and data bytes. It acknowledges a byte by requesting that the pad pull SDA low.

A valid word address appears as a one-cycle load strobe for the address pointer of a downstream page-buffer engine. Data bytes are handed to that engine over a valid/ready stream. A Stop that ends a transaction in which data was accepted raises a one-cycle commit strobe, which starts the internal write cycle. While the engine reports that a write cycle is running, the block acknowledges nothing.

Stream rules: `wr_valid_o` rises with a byte on `wr_data_o` and both hold unchanged until a cycle where `wr_ready_i` is high. Back-pressure is not applied to the bus, because clock stretching is not supported. If the previous byte is still waiting when a new data byte reaches its acknowledge decision, the new byte is refused and dropped.

Top module: `eewr_frontend`

## Requirements
- R1: A Stop (SDA rising while SCL is high) that ends a transaction with at least one accepted data byte raises `commit_o` for exactly one cycle.
- R2: After a Start (SDA falling while SCL is high), a first byte whose upper four bits are 1010 and whose bit 0 (R/W) is 0 is acknowledged. Bits 3..1 (chip select) may hold any value.
- R3: A first byte with a different upper nibble, or with bit 0 set, is not acknowledged. After it, every byte is ignored until the next Start: no acknowledge, no pointer load, no data and no commit.
- R4: The second byte is acknowledged and placed on `ptr_addr_o`, with `ptr_load_o` high for exactly one cycle.
- R5: Each later byte is acknowledged and offered on `wr_data_o` with `wr_valid_o`. The byte and the valid flag hold steady until `wr_ready_i` is high.
- R6: A data byte that completes while `wr_valid_o` is still high is not acknowledged. It is dropped, and later bytes are ignored until the next Start.
- R7: While `busy_i` is high at the acknowledge decision, no byte is acknowledged, including the control byte.
- R8: `sda_pull_o` rises only after the SCL falling edge that ends the eighth bit of a byte. It falls after the SCL falling edge that ends the ninth clock. It is never high during data bits.
- R9: A repeated Start in the middle of a transaction restarts parsing, and the next byte is treated as a control byte.
- R10: A Stop that follows a transaction with no accepted data byte produces no commit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | High while the internal write cycle runs; all acknowledges are withheld |
| sda_pull_o | output | 1 | High requests the pad to pull SDA low (acknowledge) |
| ptr_load_o | output | 1 | One-cycle strobe that loads the word address pointer |
| ptr_addr_o | output | 8 | Word address byte |
| wr_valid_o | output | 1 | Data byte available |
| wr_ready_i | input | 1 | Engine accepts the data byte in this cycle |
| wr_data_o | output | 8 | Data byte |
| commit_o | output | 1 | One-cycle strobe on a Stop that ends a transaction with accepted data |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and device code 1010. It drives SCL with a quarter period of only four system clocks, so every acknowledge edge falls close to the synchroniser latency. The eight-bit control byte is swept over all 256 values. This covers every chip-select pattern under both R/W settings, as well as every mismatching device code. Directed sequences then cover the busy input, a repeated Start, a Stop with no data, multi-byte pages and a stalled stream consumer.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_DATA,
    ST_SKIP
  } eewr_state_e;
endpackage

// File: rtl/eewr_sync.sv
module eewr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/eewr_bus_cond.sv
module eewr_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eewr_byte_rx.sv
module eewr_byte_rx
  import eewr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic              slot_open,
  output logic              slot_close,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W    = $clog2(BYTE_W + 2);
  localparam int ACK_SLOT = BYTE_W + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx_byte <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
      rx_byte <= {rx_byte[BYTE_W-2:0], sda_s};
      cnt     <= cnt + 1'b1;
    end else if (slot_open) begin
      cnt <= CNT_W'(ACK_SLOT);
    end else if (slot_close) begin
      cnt <= '0;
    end
  end

  assign slot_open  = scl_fall && (cnt == CNT_W'(BYTE_W));
  assign slot_close = scl_fall && (cnt == CNT_W'(ACK_SLOT));
endmodule

// File: rtl/eewr_ctrl_fsm.sv
module eewr_ctrl_fsm
  import eewr_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              slot_open,
  input  logic              slot_close,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              busy_i,
  input  logic              wr_ready_i,
  output logic              sda_pull_o,
  output logic              ptr_load_o,
  output logic [BYTE_W-1:0] ptr_addr_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o
);
  eewr_state_e state;
  logic        wrote;
  logic        accept;
  logic        code_ok;

  assign code_ok = (rx_byte[BYTE_W-1 -: CODE_W] == DEV_CODE) && !rx_byte[0];

  always_comb begin
    case (state)
      ST_CTRL:  accept = !busy_i && code_ok;
      ST_WADDR: accept = !busy_i;
      ST_DATA:  accept = !busy_i && !wr_valid_o;
      default:  accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wrote      <= 1'b0;
      sda_pull_o <= 1'b0;
      ptr_load_o <= 1'b0;
      ptr_addr_o <= '0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
    end else begin
      ptr_load_o <= 1'b0;
      commit_o   <= 1'b0;
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;
      if (start_det) begin
        state      <= ST_CTRL;
        sda_pull_o <= 1'b0;
        wrote      <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        commit_o   <= wrote;
        wrote      <= 1'b0;
      end else if (slot_open) begin
        sda_pull_o <= accept;
        if (!accept) begin
          state <= ST_SKIP;
        end else begin
          case (state)
            ST_CTRL: state <= ST_WADDR;
            ST_WADDR: begin
              state      <= ST_DATA;
              ptr_load_o <= 1'b1;
              ptr_addr_o <= rx_byte;
            end
            ST_DATA: begin
              wr_valid_o <= 1'b1;
              wr_data_o  <= rx_byte;
              wrote      <= 1'b1;
            end
            default: state <= ST_SKIP;
          endcase
        end
      end else if (slot_close) begin
        sda_pull_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eewr_frontend.sv
module eewr_frontend
  import eewr_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              ptr_load_o,
  output logic [BYTE_W-1:0] ptr_addr_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              slot_open, slot_close;
  logic [BYTE_W-1:0] rx_byte;

  eewr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  eewr_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eewr_byte_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start_det | stop_det),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .slot_open  (slot_open),
    .slot_close (slot_close),
    .rx_byte    (rx_byte)
  );

  eewr_ctrl_fsm #(.DEV_CODE(DEV_CODE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .slot_open  (slot_open),
    .slot_close (slot_close),
    .rx_byte    (rx_byte),
    .busy_i     (busy_i),
    .wr_ready_i (wr_ready_i),
    .sda_pull_o (sda_pull_o),
    .ptr_load_o (ptr_load_o),
    .ptr_addr_o (ptr_addr_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .commit_o   (commit_o)
  );
endmodule

// File: rtl/eewr_frontend_chk.sv
module eewr_frontend_chk
  import eewr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              busy_i,
  input logic              start_det,
  input logic              sda_pull_o,
  input logic              ptr_load_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [BYTE_W-1:0] wr_data_o,
  input logic              commit_o
);
  p_commit_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_ptr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_o |=> !ptr_load_o);

  p_hold_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o)));

  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(busy_i));

  p_ack_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_s));

  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);
endmodule

bind eewr_frontend eewr_frontend_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .busy_i     (busy_i),
  .start_det  (start_det),
  .sda_pull_o (sda_pull_o),
  .ptr_load_o (ptr_load_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_data_o  (wr_data_o),
  .commit_o   (commit_o)
);

// File: tb/tb_eewr_frontend.sv
`timescale 1ns/1ps
module tb_eewr_frontend;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       busy = 1'b0;
  logic       rdy = 1'b1;
  logic       sda_pull, ptr_load, wr_valid, commit;
  logic [7:0] ptr_addr, wr_data;
  wire        bus_sda = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  int ptr_cnt = 0, got_cnt = 0, commit_cnt = 0, stray = 0;
  logic [7:0] ptr_val = '0, got_byte = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eewr_frontend dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .busy_i(busy),
    .sda_pull_o(sda_pull), .ptr_load_o(ptr_load), .ptr_addr_o(ptr_addr),
    .wr_valid_o(wr_valid), .wr_ready_i(rdy), .wr_data_o(wr_data),
    .commit_o(commit)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && rdy) begin got_cnt++; got_byte = wr_data; end
      if (ptr_load) begin ptr_cnt++; ptr_val = ptr_addr; end
      if (commit) commit_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(Q);
      if (sda_pull) stray++;
      w(Q); scl = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
    ack = sda_pull;
    w(Q); scl = 1'b0; w(Q);
    chk(!sda_pull, "R8 release after ninth clock", int'(sda_pull), 0);
  endtask

  initial begin
    bit ack;
    int p0, g0, c0;
    w(5);
    chk(!sda_pull && !ptr_load && !wr_valid && !commit, "reset outputs", 
        int'({sda_pull, ptr_load, wr_valid, commit}), 0);
    rst_n = 1'b1;
    w(5);

    // R2 R3 sweep over every control byte
    for (int b = 0; b < 256; b++) begin
      bit exp;
      p0 = ptr_cnt; g0 = got_cnt; c0 = commit_cnt;
      exp = (b[7:4] == 4'hA) && !b[0];
      bus_start();
      send(8'(b), ack);
      chk(ack == exp, exp ? "R2 control ack" : "R3 control nack", int'(ack), int'(exp));
      if (exp) begin
        send(8'(b) ^ 8'h5A, ack);
        chk(ack, "R4 address ack", int'(ack), 1);
        chk(ptr_cnt == p0 + 1 && ptr_val == (8'(b) ^ 8'h5A), "R4 pointer",
            int'(ptr_val), int'(8'(b) ^ 8'h5A));
        send(~8'(b), ack);
        chk(ack, "R5 data ack", int'(ack), 1);
        chk(got_cnt == g0 + 1 && got_byte == ~8'(b), "R5 data byte",
            int'(got_byte), int'(~8'(b)));
        bus_stop();
        chk(commit_cnt == c0 + 1, "R1 commit", commit_cnt - c0, 1);
      end else begin
        send(8'h3C, ack);
        chk(!ack, "R3 later byte ignored", int'(ack), 0);
        bus_stop();
        chk(ptr_cnt == p0 && got_cnt == g0 && commit_cnt == c0, "R3 no side effects",
            ptr_cnt - p0 + got_cnt - g0 + commit_cnt - c0, 0);
      end
    end
    chk(stray == 0, "R8 no pull during data bits", stray, 0);

    // R7 busy at control byte
    c0 = commit_cnt; p0 = ptr_cnt;
    busy = 1'b1;
    bus_start(); send(8'hA0, ack);
    chk(!ack, "R7 control nack while busy", int'(ack), 0);
    send(8'h00, ack); bus_stop();
    busy = 1'b0;
    chk(commit_cnt == c0 && ptr_cnt == p0, "R7 nothing taken", commit_cnt - c0, 0);

    // R7 busy rises mid transaction
    bus_start(); send(8'hA6, ack);
    chk(ack, "R2 ack before busy", int'(ack), 1);
    busy = 1'b1;
    send(8'h10, ack);
    chk(!ack, "R7 address nack while busy", int'(ack), 0);
    bus_stop(); busy = 1'b0;
    chk(ptr_cnt == p0, "R7 no pointer load", ptr_cnt - p0, 0);

    // R10 stop without data
    c0 = commit_cnt;
    bus_start(); send(8'hA0, ack); send(8'h20, ack); bus_stop();
    chk(commit_cnt == c0, "R10 no commit", commit_cnt - c0, 0);
    chk(ptr_val == 8'h20, "R4 pointer before empty stop", int'(ptr_val), 32);

    // R9 repeated start
    c0 = commit_cnt; g0 = got_cnt;
    bus_start(); send(8'hA0, ack); send(8'h10, ack);
    bus_start(); send(8'hAE, ack);
    chk(ack, "R9 control after repeated start", int'(ack), 1);
    send(8'h22, ack);
    chk(ptr_val == 8'h22, "R9 new pointer", int'(ptr_val), 34);
    send(8'h77, ack); bus_stop();
    chk(got_cnt == g0 + 1 && got_byte == 8'h77, "R9 data", int'(got_byte), 119);
    chk(commit_cnt == c0 + 1, "R1 commit after repeated start", commit_cnt - c0, 1);
    bus_start(); send(8'hA0, ack); send(8'h10, ack);
    bus_start(); send(8'h10, ack);
    chk(!ack, "R9 byte after repeated start parsed as control", int'(ack), 0);
    bus_stop();

    // R5 multi-byte page
    c0 = commit_cnt; g0 = got_cnt;
    bus_start(); send(8'hA2, ack); send(8'h08, ack);
    for (int k = 1; k <= 5; k++) begin
      send(8'(k * 17), ack);
      chk(ack && got_byte == 8'(k * 17), "R5 page byte", int'(got_byte), k * 17);
    end
    bus_stop();
    chk(got_cnt == g0 + 5, "R5 page count", got_cnt - g0, 5);
    chk(commit_cnt == c0 + 1, "R1 page commit", commit_cnt - c0, 1);

    // R6 back-pressure
    c0 = commit_cnt; g0 = got_cnt;
    rdy = 1'b0;
    bus_start(); send(8'hA0, ack); send(8'h40, ack); send(8'h81, ack);
    chk(ack && wr_valid && wr_data == 8'h81, "R5 held byte", int'(wr_data), 129);
    send(8'h82, ack);
    chk(!ack, "R6 nack when stream full", int'(ack), 0);
    send(8'h83, ack);
    chk(!ack, "R6 ignored after refusal", int'(ack), 0);
    chk(wr_valid && wr_data == 8'h81, "R5 still held", int'(wr_data), 129);
    bus_stop();
    chk(commit_cnt == c0 + 1, "R1 commit after refusal", commit_cnt - c0, 1);
    rdy = 1'b1; w(4);
    chk(got_cnt == g0 + 1 && got_byte == 8'h81, "R6 only first byte passed",
        got_cnt - g0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule